// File: doc/BRIEF.md
# Serial LED Status Shifter

This block turns a set of hub status flags into a short serial stream for an external shift register that drives a row of LEDs. At a fixed frame interval it takes one snapshot of the status inputs and sends the result as 24 data bits, least significant first. A strobe clock runs only for the length of the burst and stays low at all other times. The flags are per-port partition state, receive activity per port, one collision flag for each speed domain, and a memory self-test failure flag. The external register latches each bit on a rising strobe edge, so after the 24th pulse it holds a full, consistent picture of the hub.

Each strobe pulse lasts `2*HALF_CYC` system clocks: `HALF_CYC` low, then `HALF_CYC` high. With a 50 MHz clock and the default of 4, this gives a 160 ns period with 80 ns of data setup and 80 ns of hold around each rising edge. `FRAME_CYC` sets the spacing between bursts. Its default of 2,100,000 cycles equals 42 ms. The data line changes only while the strobe is low, on the same clock edge at which the strobe falls.

Top module: `led_status_serializer`

## Requirements
- R1: Every burst has exactly 24 rising edges on `led_clk`. Outside a burst, `led_clk` stays low.
- R2: Each strobe pulse is high for `HALF_CYC` system clocks. It is low for `HALF_CYC` system clocks before its rising edge, both before the first pulse and between pulses.
- R3: The first burst begins on the first clock edge after reset is released, so its first rising strobe comes `HALF_CYC+1` edges after release. Each later burst starts exactly `FRAME_CYC` clocks after the previous one.
- R4: Frame bit 0 is sent on the first pulse of a burst and frame bit 23 on the last. Bit k is the value of `led_dat` at the k-th rising edge of `led_clk`, counting from 0.
- R5: Frame bits 0 to 7 carry `port_part[0]` to `port_part[7]`. Bit 8 carries `col_10m`, bit 9 carries `col_100m` and bit 10 carries `mem_fail`.
- R6: Frame bits 11 to 15 carry `port_part[3]` to `port_part[7]` again. Bits 16 to 23 carry `port_rx_act[0]` to `port_rx_act[7]`.
- R7: The data is active high: a status flag at 1 sends a 1 and a flag at 0 sends a 0.
- R8: Within a burst, `led_dat` changes only on the edge where `led_clk` falls, or when the burst starts. It is stable for at least `HALF_CYC` clocks before every rising edge and while the strobe is high.
- R9: All 24 bits come from a single snapshot of the inputs taken at the start of the burst. Input changes during a burst first appear in the next burst.
- R10: While reset is low, both outputs are low. Between bursts, `led_dat` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_part | input | 8 | Partition flag per port |
| col_10m | input | 1 | Collision flag of the 10 Mb/s domain |
| col_100m | input | 1 | Collision flag of the 100 Mb/s domain |
| mem_fail | input | 1 | Memory self-test failure flag |
| port_rx_act | input | 8 | Receive-activity flag per port |
| led_dat | output | 1 | Serial LED data, active high |
| led_clk | output | 1 | Bursted strobe clock, idles low |

## Verification
The first burst starts on the first edge after reset release, and the first rising strobe follows `HALF_CYC+1` edges after release. Each later burst's first rising strobe comes exactly `FRAME_CYC` edges after the previous one. Every output change happens on a clock edge and is visible one edge later. The bench therefore samples both outputs on falling clock edges and keeps a cycle count of rising edges, so every interval it checks is an exact number of edges. A frame bit is read at the sample where the strobe is first seen high. Pulse widths and data stability are counted sample by sample. Input changes are made on falling edges, between bursts or at a chosen pulse inside one, so the snapshot edge for each burst is never ambiguous.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;

  localparam int NUM_PORTS  = 8;
  localparam int FRAME_BITS = 24;
  localparam int MIRROR_LO  = 3;   // first port repeated in the upper partition group

  typedef logic [FRAME_BITS-1:0] led_frame_t;

  // Assemble the 24-bit frame; bit 0 leaves the block first.
  function automatic led_frame_t build_frame(
      input logic [NUM_PORTS-1:0] part,
      input logic                 coll_slow,
      input logic                 coll_fast,
      input logic                 memfail,
      input logic [NUM_PORTS-1:0] rxact);
    led_frame_t f;
    f = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      f[p]             = part[p];
      f[2*NUM_PORTS+p] = rxact[p];
    end
    f[NUM_PORTS]   = coll_slow;
    f[NUM_PORTS+1] = coll_fast;
    f[NUM_PORTS+2] = memfail;
    for (int p = MIRROR_LO; p < NUM_PORTS; p++) begin
      f[NUM_PORTS+p] = part[p];
    end
    return f;
  endfunction

  // A strobe phase index is in the high half once it reaches the half length.
  function automatic logic phase_high(input int unsigned ph, input int unsigned half);
    return ph >= half;
  endfunction

endpackage

// File: rtl/led_frame_timer.sv
module led_frame_timer #(
  parameter int FRAME_CYC = 2_100_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic frame_tick
);
  localparam int CW = (FRAME_CYC > 1) ? $clog2(FRAME_CYC) : 1;
  localparam logic [CW-1:0] WRAP = CW'(FRAME_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt == WRAP) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign frame_tick = (cnt == '0);
endmodule

// File: rtl/led_bit_sequencer.sv
module led_bit_sequencer
  import led_ser_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int NBITS    = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic strobe_high,
  output logic advance
);
  localparam int PH_N = 2 * HALF_CYC;
  localparam int PW   = (PH_N > 1) ? $clog2(PH_N) : 1;
  localparam int IW   = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [PW-1:0] PH_LAST  = PW'(PH_N - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(NBITS - 1);

  logic [PW-1:0] ph;
  logic [IW-1:0] idx;
  logic          last_bit;

  assign last_bit    = (idx == IDX_LAST);
  assign advance     = active && (ph == PH_LAST);
  assign strobe_high = active && phase_high(int'(ph), HALF_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph     <= '0;
      idx    <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        ph     <= '0;
        idx    <= '0;
      end
    end else if (advance) begin
      ph <= '0;
      if (last_bit) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end else begin
      ph <= ph + 1'b1;
    end
  end
endmodule

// File: rtl/led_snapshot_shifter.sv
module led_snapshot_shifter #(
  parameter int NBITS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [NBITS-1:0] frame_in,
  output logic             head_bit
);
  logic [NBITS-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
    end else if (load) begin
      sreg <= frame_in;
    end else if (shift) begin
      sreg <= {1'b0, sreg[NBITS-1:1]};
    end
  end

  assign head_bit = sreg[0];
endmodule

// File: rtl/led_status_serializer.sv
module led_status_serializer
  import led_ser_pkg::*;
#(
  parameter int HALF_CYC  = 4,
  parameter int FRAME_CYC = 2_100_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] port_part,
  input  logic                 col_10m,
  input  logic                 col_100m,
  input  logic                 mem_fail,
  input  logic [NUM_PORTS-1:0] port_rx_act,
  output logic                 led_dat,
  output logic                 led_clk
);
  localparam int NBITS = FRAME_BITS;

  // Named internal events, visible to the bound checker.
  logic       frame_tick;
  logic       burst_start;
  logic       burst_active;
  logic       bit_advance;
  logic       strobe_high;
  logic       shift_head;
  led_frame_t frame_now;

  assign frame_now   = build_frame(port_part, col_10m, col_100m, mem_fail, port_rx_act);
  assign burst_start = frame_tick && !burst_active;

  led_frame_timer #(.FRAME_CYC(FRAME_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick)
  );

  led_bit_sequencer #(.HALF_CYC(HALF_CYC), .NBITS(NBITS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (burst_start),
    .active      (burst_active),
    .strobe_high (strobe_high),
    .advance     (bit_advance)
  );

  led_snapshot_shifter #(.NBITS(NBITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (burst_start),
    .shift    (bit_advance),
    .frame_in (frame_now),
    .head_bit (shift_head)
  );

  assign led_clk = strobe_high;
  assign led_dat = burst_active && shift_head;
endmodule

// File: rtl/led_status_serializer_chk.sv
module led_status_serializer_chk #(
  parameter int HALF_CYC  = 4,
  parameter int FRAME_CYC = 2_100_000,
  parameter int NBITS     = 24
) (
  input logic clk,
  input logic rst_n,
  input logic led_clk,
  input logic led_dat,
  input logic burst_start,
  input logic burst_active
);
  localparam int GW = $clog2(FRAME_CYC + 1) + 1;
  localparam int HW = $clog2(HALF_CYC + 1) + 1;
  localparam int NW = $clog2(NBITS + 1) + 1;

  logic          clk_d;
  logic          seen_start;
  logic [GW-1:0] gap;
  logic [HW-1:0] hi_run;
  logic [NW-1:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d      <= 1'b0;
      seen_start <= 1'b0;
      gap        <= '0;
      hi_run     <= '0;
      rises      <= '0;
    end else begin
      clk_d <= led_clk;
      if (burst_start) seen_start <= 1'b1;
      gap    <= burst_start ? '0 : gap + 1'b1;
      hi_run <= led_clk ? hi_run + 1'b1 : '0;
      if (burst_start)             rises <= '0;
      else if (led_clk && !clk_d)  rises <= rises + 1'b1;
    end
  end

  // R1
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_active |-> !led_clk);

  // R10
  idle_dat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_active |-> !led_dat);

  // R1
  pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_active) |-> (rises == NW'(NBITS)));

  // R2
  high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(led_clk) |-> (hi_run == HW'(HALF_CYC)));

  // R3
  frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && seen_start) |-> (gap == GW'(FRAME_CYC - 1)));

  // R8
  dat_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (led_clk && $past(led_clk)) |-> $stable(led_dat));

  // R8
  dat_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && $past(burst_active) && !$stable(led_dat)) |-> $fell(led_clk));
endmodule

bind led_status_serializer led_status_serializer_chk #(
  .HALF_CYC  (HALF_CYC),
  .FRAME_CYC (FRAME_CYC),
  .NBITS     (NBITS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .led_clk      (led_clk),
  .led_dat      (led_dat),
  .burst_start  (burst_start),
  .burst_active (burst_active)
);

// File: tb/led_status_serializer_tb.sv
module led_status_serializer_tb;
  localparam int HALF  = 4;
  localparam int FRAME = 400;
  localparam int NB    = 24;
  localparam int WDOG  = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] stim = '0;   // [7:0] partition, [8] col10, [9] col100, [10] memfail, [18:11] rx activity
  wire         led_dat;
  wire         led_clk;

  always #5 clk = ~clk;

  led_status_serializer #(.HALF_CYC(HALF), .FRAME_CYC(FRAME)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_part   (stim[7:0]),
    .col_10m     (stim[8]),
    .col_100m    (stim[9]),
    .mem_fail    (stim[10]),
    .port_rx_act (stim[18:11]),
    .led_dat     (led_dat),
    .led_clk     (led_clk)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG && !finished) begin
      $display("FAIL watchdog: actual run of %0d cycles, expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected frame restated from R5/R6.
  function automatic logic [NB-1:0] expect_bits(input logic [18:0] s);
    logic [NB-1:0] e;
    for (int i = 0; i < NB; i++) begin
      if (i < 8)       e[i] = s[i];
      else if (i < 11) e[i] = s[i];
      else if (i < 16) e[i] = s[i - 8];
      else             e[i] = s[i - 5];
    end
    return e;
  endfunction

  // Watches one burst, sampling on falling edges of clk.
  task automatic grab_burst(input int swap_at, input logic [18:0] swap_val,
                            output logic [NB-1:0] bits, output int npulse,
                            output int first_rise, output int bad_width,
                            output int bad_hold, output bit timed_out);
    int   stab, hi, lo, t;
    logic last_d, prev_c;
    bits = '0; npulse = 0; first_rise = -1; bad_width = 0; bad_hold = 0; timed_out = 0;
    stab = 0; hi = 0; lo = 0; t = 0;
    last_d = led_dat;
    forever begin
      @(negedge clk);
      if (led_clk) break;
      if (led_dat === last_d) stab++;
      else begin stab = 1; last_d = led_dat; end
      t++;
      if (t > 2 * FRAME) begin timed_out = 1; return; end
    end
    if (stab < HALF) bad_hold++;
    bits[0] = led_dat; npulse = 1; first_rise = cyc; hi = 1; prev_c = 1'b1;
    if (swap_at == 1) stim = swap_val;
    forever begin
      @(negedge clk);
      if (led_clk) begin
        if (!prev_c) begin
          if (stab < HALF) bad_hold++;
          if (lo != HALF) bad_width++;
          if (npulse < NB) bits[npulse] = led_dat;
          npulse++;
          hi = 1;
          last_d = led_dat;
          if (npulse == swap_at) stim = swap_val;
        end else begin
          hi++;
          if (led_dat !== last_d) bad_hold++;
        end
      end else begin
        if (prev_c) begin
          if (hi != HALF) bad_width++;
          lo = 1;
        end else begin
          lo++;
        end
        if (led_dat === last_d) stab++;
        else begin stab = 1; last_d = led_dat; end
        if (lo > 2 * HALF) break;
      end
      prev_c = led_clk;
    end
  endtask

  logic [NB-1:0] g_bits;
  int g_n, g_rise, g_bw, g_bh, prev_rise;
  bit g_to;

  task automatic t_reset();
    int hits = 0;
    rst_n = 1'b0;
    stim  = {8'hA1, 1'b1, 1'b0, 1'b1, 8'h2C};
    repeat (20) begin
      @(negedge clk);
      if (led_clk !== 1'b0 || led_dat !== 1'b0) hits++;
    end
    check("R10", "outputs high during reset", hits, 0);
  endtask

  task automatic t_first_burst();
    int rel;
    @(negedge clk);
    rst_n = 1'b1;
    rel = cyc;
    grab_burst(-1, '0, g_bits, g_n, g_rise, g_bw, g_bh, g_to);
    check("R3", "first burst timeout", g_to, 0);
    check("R3", "first rise edge after release", g_rise - rel, HALF + 1);
    check("R1", "pulses in first burst", g_n, NB);
    check("R2", "pulse width errors", g_bw, 0);
    check("R8", "data setup/hold errors", g_bh, 0);
    check("R4", "bit 0 sent first (partition port 0)", g_bits[0], stim[0]);
    check("R5", "low frame field", g_bits[10:0], expect_bits(stim) & 24'h0007FF);
    check("R6", "high frame field", g_bits[23:11], expect_bits(stim) >> 11);
    prev_rise = g_rise;
  endtask

  task automatic t_period();
    grab_burst(-1, '0, g_bits, g_n, g_rise, g_bw, g_bh, g_to);
    check("R3", "burst spacing", g_rise - prev_rise, FRAME);
    check("R1", "pulses in second burst", g_n, NB);
    prev_rise = g_rise;
  endtask

  task automatic t_idle();
    int hits = 0;
    repeat (100) begin
      @(negedge clk);
      if (led_clk !== 1'b0) hits++;
      if (led_dat !== 1'b0) hits++;
    end
    check("R1", "strobe or data high between bursts (R10)", hits, 0);
  endtask

  task automatic t_pattern(input string req, input string what, input logic [18:0] val);
    stim = val;
    grab_burst(-1, '0, g_bits, g_n, g_rise, g_bw, g_bh, g_to);
    check(req, {what, " pulses"}, g_n, NB);
    check(req, what, g_bits, expect_bits(val));
    check("R2", {what, " width errors"}, g_bw, 0);
  endtask

  task automatic t_snapshot();
    logic [18:0] a = {8'h3C, 1'b0, 1'b1, 1'b0, 8'h96};
    logic [18:0] b = {8'hC3, 1'b1, 1'b0, 1'b1, 8'h69};
    stim = a;
    grab_burst(5, b, g_bits, g_n, g_rise, g_bw, g_bh, g_to);
    check("R9", "burst keeps snapshot despite mid-burst change", g_bits, expect_bits(a));
    grab_burst(-1, '0, g_bits, g_n, g_rise, g_bw, g_bh, g_to);
    check("R9", "next burst shows new inputs", g_bits, expect_bits(b));
  endtask

  initial begin
    t_reset();
    t_first_burst();
    t_period();
    t_idle();
    t_pattern("R7", "all flags clear", 19'h00000);
    t_pattern("R7", "all flags set", 19'h7FFFF);
    t_pattern("R5", "only 10M collision", 19'h00100);
    t_pattern("R5", "only 100M collision", 19'h00200);
    t_pattern("R5", "only memory fail", 19'h00400);
    t_pattern("R6", "port 3 partition mirrored", 19'h00008);
    t_pattern("R6", "port 7 partition mirrored", 19'h00080);
    t_pattern("R6", "port 0 rx activity", 19'h00800);
    t_pattern("R4", "port 7 rx activity last", 19'h40000);
    t_snapshot();
    t_idle();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule